// File: doc/BRIEF.md
# Dual-Modulus 32/33 Clock Divider

This block divides its input clock by 32 or by 33, picked by a single modulus input. At its core is a small divide-by-2-or-3 cell. The cell holds two state bits, and each bit's next value is formed by a NOR-type gating term. A chain of four toggle stages follows the cell and counts its output periods. After sixteen cell periods, one output period is complete. When the longer ratio is selected, control logic asks the cell to stretch exactly one of those sixteen periods from 2 to 3 input cycles. That period is the last one before the boundary, when every toggle stage reads one.

Whenever the cell divides by 2, its first state bit is held still instead of being reloaded. This is the logical model of switching that flip-flop off. The modulus input is latched only at an output-period boundary, so every period is a clean 32 or 33. All toggle stages run on the input clock through synchronous enables. Their cycle counts match those of a ripple chain, and a single clock domain is enough.

Top module: `dmp_prescaler`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, `div_clk` reads 1 and `cell_div3` reads 0. The cell, the toggle stages and the latched modulus return to their initial state, and the latched modulus loads the current `mod_sel`.
- R2: With `mod_sel` = 1 latched, every output period is 32 input cycles, measured from one rising edge of `div_clk` to the next. Of these, `div_clk` is high for 16 cycles and low for 16, and `cell_div3` stays 0 for the whole period.
- R3: With `mod_sel` = 0 latched, every output period is 33 input cycles, with `div_clk` high for 16 cycles and low for 17.
- R4: In a 33-cycle period, `cell_div3` is 1 for exactly three consecutive cycles. These are the last three cycles before `div_clk` rises, all within its low phase. The cell's first state bit changes only on an edge that follows a cycle in which `cell_div3` was 1.
- R5: `mod_sel` is sampled only on the clock edge at which `div_clk` rises, and on reset edges. A change at any other time has no effect on the period in progress and governs the period after it.
- R6: After reset is released, `div_clk` first rises on the 32nd or 33rd clock edge. The choice follows the `mod_sel` value seen during the last reset cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| mod_sel | input | 1 | Modulus select: 1 divides by 32, 0 divides by 33 |
| div_clk | output | 1 | Divided clock; its rising edge marks each period boundary |
| cell_div3 | output | 1 | High while the 2/3 cell is in its divide-by-3 mode |

## Verification
The bound checker watches the cell on every cycle. It confirms that the first state bit holds in divide-by-2 mode and that the two cell bits are never both set. It also checks that every divide-by-3 request lasts exactly three cycles inside the low phase, and that each rising-edge gap is 32 or 33 cycles. Some behaviours show only in the bench's scenarios, because they depend on what was requested and when. These are matching each period length to the selected ratio, deferring a mid-period modulus change, and deriving the first period after reset from the value captured during reset.

// File: rtl/dmp_pkg.sv
package dmp_pkg;

    // number of toggle stages behind the 2/3 cell
    localparam int unsigned STAGES_DEF = 4;

    // two-bit state of the 2/3 cell; bit "hold" is the one frozen in div-2 mode
    typedef struct packed {
        logic hold;
        logic outb;
    } cell_st_t;

    // reset lands just after a cell period boundary
    localparam cell_st_t CELL_RESET = '{hold: 1'b0, outb: 1'b1};

    // shortest total ratio for a given stage count
    function automatic int unsigned low_ratio(input int unsigned stages);
        return 2 ** (stages + 1);
    endfunction

endpackage

// File: rtl/dmp_cell23.sv
module dmp_cell23
    import dmp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mc,
    output logic period_end,
    output logic out_q,
    output logic hold_q
);

    cell_st_t st;
    cell_st_t st_n;
    logic     nor_out;
    logic     nor_hold;

    always_comb begin
        // output bit: NOR of both state bits
        nor_out  = ~(st.outb | st.hold);
        // hold bit: NOR of inverted output and the control
        nor_hold = ~(~st.outb | mc);
        st_n.outb = nor_out;
        // freeze the hold bit entirely while dividing by two
        st_n.hold = mc ? st.hold : nor_hold;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= CELL_RESET;
        end else begin
            st <= st_n;
        end
    end

    assign period_end = nor_out;
    assign out_q      = st.outb;
    assign hold_q     = st.hold;

endmodule

// File: rtl/dmp_toggle_chain.sv
module dmp_toggle_chain #(
    parameter int unsigned STAGES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    output logic [STAGES-1:0] stage_q,
    output logic              terminal,
    output logic              wrap
);

    logic [STAGES:0] carry;

    assign carry[0] = advance;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        assign carry[g+1] = carry[g] & stage_q[g];

        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[g] <= 1'b0;
            end else if (carry[g]) begin
                stage_q[g] <= ~stage_q[g];
            end
        end
    end

    assign terminal = &stage_q;
    assign wrap     = carry[STAGES];

endmodule

// File: rtl/dmp_mod_ctrl.sv
module dmp_mod_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic mod_sel,
    input  logic terminal,
    input  logic wrap,
    output logic mc
);

    logic mod_lat;

    // modulus captured only at a period boundary or at reset
    always_ff @(posedge clk) begin
        if (rst || wrap) begin
            mod_lat <= mod_sel;
        end
    end

    // divide-by-3 request only in the terminal cell period of a 33 count
    assign mc = mod_lat | ~terminal;

endmodule

// File: rtl/dmp_prescaler.sv
module dmp_prescaler
    import dmp_pkg::*;
#(
    parameter int unsigned STAGES = STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic mod_sel,
    output logic div_clk,
    output logic cell_div3
);

    logic              mc;
    logic              cell_end;
    logic              cell_out;
    logic              cell_hold;
    logic [STAGES-1:0] stage_q;
    logic              terminal;
    logic              wrap;

    dmp_cell23 u_cell (
        .clk        (clk),
        .rst        (rst),
        .mc         (mc),
        .period_end (cell_end),
        .out_q      (cell_out),
        .hold_q     (cell_hold)
    );

    dmp_toggle_chain #(.STAGES(STAGES)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .advance  (cell_end),
        .stage_q  (stage_q),
        .terminal (terminal),
        .wrap     (wrap)
    );

    dmp_mod_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .mod_sel  (mod_sel),
        .terminal (terminal),
        .wrap     (wrap),
        .mc       (mc)
    );

    assign div_clk   = ~stage_q[STAGES-1];
    assign cell_div3 = ~mc;

endmodule

// File: rtl/dmp_prescaler_chk.sv
module dmp_prescaler_chk
    import dmp_pkg::*;
#(
    parameter int unsigned STAGES = STAGES_DEF
) (
    input logic clk,
    input logic rst,
    input logic div_clk,
    input logic cell_div3,
    input logic cell_hold,
    input logic cell_out
);

    localparam int unsigned RLO = low_ratio(STAGES);
    localparam int unsigned GW  = $clog2(RLO + 2) + 1;

    logic          div_d;
    logic [GW-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_d <= 1'b1;
            gap   <= '0;
        end else begin
            div_d <= div_clk;
            if (div_clk && !div_d) begin
                gap <= GW'(1);
            end else begin
                gap <= gap + GW'(1);
            end
        end
    end

    // R4
    hold_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !cell_div3 |=> $stable(cell_hold));

    // R4
    cell_state_chk: assert property (@(posedge clk) disable iff (rst)
        !(cell_hold && cell_out));

    // R4
    div3_run_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cell_div3) |=> cell_div3 ##1 cell_div3 ##1 !cell_div3);

    // R4
    div3_phase_chk: assert property (@(posedge clk) disable iff (rst)
        cell_div3 |-> !div_clk);

    // R2
    div2_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (!cell_div3 && !cell_hold) |=> (cell_out != $past(cell_out)));

    // R3
    period_len_chk: assert property (@(posedge clk) disable iff (rst)
        (div_clk && !div_d) |-> (gap == GW'(RLO) || gap == GW'(RLO + 1)));

endmodule

bind dmp_prescaler dmp_prescaler_chk #(.STAGES(STAGES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .div_clk   (div_clk),
    .cell_div3 (cell_div3),
    .cell_hold (cell_hold),
    .cell_out  (cell_out)
);

// File: tb/tb_dmp_prescaler.sv
`timescale 1ns/1ps
module tb_dmp_prescaler;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mod_sel = 1'b1;
    logic div_clk;
    logic cell_div3;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dmp_prescaler dut (
        .clk       (clk),
        .rst       (rst),
        .mod_sel   (mod_sel),
        .div_clk   (div_clk),
        .cell_div3 (cell_div3)
    );

    localparam int NV = 6;
    localparam logic TBL_MOD [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
    localparam int   TBL_P   [NV] = '{33, 33, 32, 33, 32, 32};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called just after a rising edge of div_clk (or a reset release), sampled at negedge.
    task automatic measure(input int exp_p, input string req, input int flip_at, input logic flip_val);
        int n = 0;
        int hi;
        int d3 = 0;
        int first3 = -1;
        int last3 = -1;
        logic prev;
        hi = div_clk ? 1 : 0;
        prev = div_clk;
        forever begin
            @(negedge clk);
            n++;
            if (div_clk && !prev) break;
            if (n == flip_at) mod_sel = flip_val;
            prev = div_clk;
            if (div_clk) hi++;
            if (cell_div3) begin
                d3++;
                if (first3 < 0) first3 = n;
                last3 = n;
            end
            if (n > 200) begin
                check(1'b0, {req, " timeout"}, n, exp_p);
                return;
            end
        end
        check(n == exp_p, {req, " period"}, n, exp_p);
        check(hi == 16, {req, " high phase"}, hi, 16);
        if (exp_p == 33) begin
            check(d3 == 3, "R4 div3 cycles", d3, 3);
            check(first3 == exp_p - 3, "R4 div3 first", first3, exp_p - 3);
            check(last3 == exp_p - 1, "R4 div3 last", last3, exp_p - 1);
        end else begin
            check(d3 == 0, "R2 no div3", d3, 0);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int prev_p;
        // R1: reset state
        mod_sel = 1'b1;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(div_clk == 1'b1, "R1 div_clk", div_clk, 1);
        check(cell_div3 == 1'b0, "R1 cell_div3", cell_div3, 0);
        rst = 1'b0;
        // R6: first period from release, ratio 32
        measure(32, "R6", -1, 1'b0);

        // table walk; a value set right after a boundary rules the following period (R5)
        prev_p = 32;
        for (int i = 0; i < NV; i++) begin
            mod_sel = TBL_MOD[i];
            measure(prev_p, (prev_p == 32) ? "R2" : "R3", -1, 1'b0);
            prev_p = TBL_P[i];
        end
        measure(prev_p, "R2", -1, 1'b0);

        // R5: mid-period changes are deferred
        measure(32, "R5", 10, 1'b0);
        measure(33, "R5", 31, 1'b1);
        measure(32, "R5", -1, 1'b0);

        // R1 and R6: reset mid-period with ratio 33
        mod_sel = 1'b0;
        repeat (7) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(div_clk == 1'b1, "R1 div_clk mid", div_clk, 1);
        check(cell_div3 == 1'b0, "R1 cell_div3 mid", cell_div3, 0);
        rst = 1'b0;
        measure(33, "R6", -1, 1'b0);

        // R6: value during reset rules, later change waits for the boundary
        mod_sel = 1'b1;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        measure(32, "R6", 1, 1'b0);
        measure(33, "R3", -1, 1'b0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule